// File: doc/BRIEF.md
# Multi-Channel Lane Steering Write Front End

This block sits between a 40-bit write data bus and the write ports of up to four independent FIFO channels. A static configuration chooses quad operation, where every channel receives its own 10-bit lane, or dual operation, where only channels 0 and 2 are live and each takes a 10-bit or 20-bit lane. For every live channel the block qualifies the channel's active-low write enable and chip select, respects that channel's full indication, and issues a one-cycle write strobe with the steered data word to the storage behind it.

Each channel runs on its own clock, which is independent of the other channels. Double-data-rate capture is modelled synthesizably. Every channel clock runs at twice the write rate, and a phase input marks each cycle as the rising or falling slot of the notional write clock. Enables are sampled only in the rising slot. When double-data-rate mode is on, that same decision is reused in the following falling slot, so two words can be written per write-clock period. Configuration inputs are treated as static and may change only while reset is held.

Top module: `lane_write_frontend`

## Requirements
- R1: In quad mode (`dual_mode_i`=0), channel c writes data bits [10c+9:10c] into bits [9:0] of its 20-bit output word, with bits [19:10] zero, for c = 0..3.
- R2: In dual mode with `lane_wide_i`=1, channel 0 writes data bits [19:0] and channel 2 writes data bits [39:20], as full 20-bit words.
- R3: In dual mode with `lane_wide_i`=0, channel 0 writes data bits [9:0] and channel 2 writes data bits [29:20] into bits [9:0], with bits [19:10] zero.
- R4: In dual mode, channels 1 and 3 never assert their write strobe.
- R5: With `ddr_i`=0, a channel writes only in a rising slot (`phase_i`=1) and only when both its `wen_ni` and `wcs_ni` are low in that slot. A falling slot (`phase_i`=0) never writes.
- R6: With `ddr_i`=1, a channel whose enables were both low in a rising slot also writes in the immediately following falling slot. Enable values during a falling slot are ignored.
- R7: A channel whose `full_i` is high in a slot does not write in that slot. This applies to both rising and falling slots.
- R8: The write strobe and data for a slot appear on the outputs after the channel clock edge that samples the slot, and the strobe lasts one cycle. After reset, all strobes and data words are zero.
- R9: Each channel is clocked only by its own clock. A channel whose clock is stopped keeps its outputs unchanged while the other channels write.
- R10: A channel's output data word changes only when that channel writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 4 | Per-channel clock at twice the write rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 4 | Per-channel slot marker: 1 = rising slot, 0 = falling slot |
| dual_mode_i | input | 1 | 0 = quad, 1 = dual (static) |
| lane_wide_i | input | 1 | Dual mode lane width: 1 = 20 bits, 0 = 10 bits (static) |
| ddr_i | input | 1 | 1 = write in both slots (static) |
| data_i | input | 40 | Shared write data bus |
| wen_ni | input | 4 | Per-channel active-low write enable |
| wcs_ni | input | 4 | Per-channel active-low chip select |
| full_i | input | 4 | Per-channel full indication from storage |
| wr_o | output | 4 | Per-channel write strobe |
| wdata_o | output | 80 | Per-channel 20-bit write words, channel c at bits [20c+19:20c] |

## Verification
The bench targets lane steering in each of the three configurations. A swapped or misaligned slice shows up as the wrong data bits on a channel, and a missing zero-extension shows up as stray upper bits in the narrow modes. It drives enables that toggle during falling slots in double-data-rate mode. A design that resamples them in the falling slot would drop or add a word. It asserts full only in a falling slot, which catches a design that checks full only at the rising edge. It also stops one channel's clock while the others write, and it checks that an odd channel stays silent in dual mode even when its enables are low.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    CFG_QUAD     = 2'd0,
    CFG_DUAL_X20 = 2'd1,
    CFG_DUAL_X10 = 2'd2
  } lane_cfg_e;

  function automatic lane_cfg_e decode_cfg(input logic dual, input logic wide);
    if (!dual)     return CFG_QUAD;
    else if (wide) return CFG_DUAL_X20;
    else           return CFG_DUAL_X10;
  endfunction
endpackage

// File: rtl/lwf_lane_mux.sv
module lwf_lane_mux
  import lwf_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int LANE_W = 10,
  localparam int DW    = NCH * LANE_W,
  localparam int CH_W  = 2 * LANE_W
) (
  input  lane_cfg_e             cfg_i,
  input  logic [DW-1:0]         data_i,
  output logic [NCH-1:0]        active_o,
  output logic [NCH*CH_W-1:0]   lane_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LANE_W-1:0] narrow;
    assign narrow = data_i[c*LANE_W +: LANE_W];
    if (c % 2 == 0) begin : g_even
      logic [CH_W-1:0] wide;
      assign wide = data_i[c*LANE_W +: CH_W];
      assign active_o[c] = 1'b1;
      always_comb begin
        unique case (cfg_i)
          CFG_DUAL_X20: lane_o[c*CH_W +: CH_W] = wide;
          default:      lane_o[c*CH_W +: CH_W] = {{LANE_W{1'b0}}, narrow};
        endcase
      end
    end else begin : g_odd
      // odd channels exist only in quad mode
      assign active_o[c] = (cfg_i == CFG_QUAD);
      assign lane_o[c*CH_W +: CH_W] = {{LANE_W{1'b0}}, narrow};
    end
  end
endmodule

// File: rtl/lwf_chan_ctrl.sv
module lwf_chan_ctrl #(
  parameter int CH_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            phase_i,
  input  logic            ddr_i,
  input  logic            active_i,
  input  logic            wen_ni,
  input  logic            wcs_ni,
  input  logic            full_i,
  input  logic [CH_W-1:0] lane_i,
  output logic            wr_o,
  output logic [CH_W-1:0] wdata_o
);
  logic en_now, en_q, do_wr;

  assign en_now = active_i & ~wen_ni & ~wcs_ni;
  // falling slot reuses the rising-slot decision
  assign do_wr  = ~full_i & (phase_i ? en_now : (ddr_i & en_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      if (phase_i) en_q <= en_now;
      wr_o <= do_wr;
      if (do_wr) wdata_o <= lane_i;
    end
  end
endmodule

// File: rtl/lane_write_frontend.sv
module lane_write_frontend
  import lwf_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int LANE_W = 10,
  localparam int DW    = NCH * LANE_W,
  localparam int CH_W  = 2 * LANE_W
) (
  input  logic [NCH-1:0]      clk2x_i,
  input  logic                rst_ni,
  input  logic [NCH-1:0]      phase_i,
  input  logic                dual_mode_i,
  input  logic                lane_wide_i,
  input  logic                ddr_i,
  input  logic [DW-1:0]       data_i,
  input  logic [NCH-1:0]      wen_ni,
  input  logic [NCH-1:0]      wcs_ni,
  input  logic [NCH-1:0]      full_i,
  output logic [NCH-1:0]      wr_o,
  output logic [NCH*CH_W-1:0] wdata_o
);
  lane_cfg_e            cfg;
  logic [NCH-1:0]       active;
  logic [NCH*CH_W-1:0]  lanes;

  assign cfg = decode_cfg(dual_mode_i, lane_wide_i);

  lwf_lane_mux #(.NCH(NCH), .LANE_W(LANE_W)) u_mux (
    .cfg_i   (cfg),
    .data_i  (data_i),
    .active_o(active),
    .lane_o  (lanes)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    lwf_chan_ctrl #(.CH_W(CH_W)) u_ctrl (
      .clk_i   (clk2x_i[c]),
      .rst_ni  (rst_ni),
      .phase_i (phase_i[c]),
      .ddr_i   (ddr_i),
      .active_i(active[c]),
      .wen_ni  (wen_ni[c]),
      .wcs_ni  (wcs_ni[c]),
      .full_i  (full_i[c]),
      .lane_i  (lanes[c*CH_W +: CH_W]),
      .wr_o    (wr_o[c]),
      .wdata_o (wdata_o[c*CH_W +: CH_W])
    );
  end
endmodule

// File: rtl/lwf_checker.sv
module lwf_checker #(
  parameter int NCH    = 4,
  parameter int LANE_W = 10,
  localparam int CH_W  = 2 * LANE_W
) (
  input logic [NCH-1:0]      clk2x_i,
  input logic                rst_ni,
  input logic [NCH-1:0]      phase_i,
  input logic                dual_mode_i,
  input logic                ddr_i,
  input logic [NCH-1:0]      wen_ni,
  input logic [NCH-1:0]      wcs_ni,
  input logic [NCH-1:0]      full_i,
  input logic [NCH-1:0]      wr_o,
  input logic [NCH*CH_W-1:0] wdata_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    if (c % 2 == 1) begin : g_odd
      assert_unused_idle_R4: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
        dual_mode_i |=> !wr_o[c]);
    end
    assert_full_blocks_R7: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
      full_i[c] |=> !wr_o[c]);
    assert_sdr_falling_R5: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
      (!ddr_i && !phase_i[c]) |=> !wr_o[c]);
    assert_enable_gate_R5: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
      (phase_i[c] && (wen_ni[c] || wcs_ni[c])) |=> !wr_o[c]);
    assert_data_hold_R10: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
      !wr_o[c] |-> $stable(wdata_o[c*CH_W +: CH_W]));
    assert_single_pulse_R8: assert property (@(posedge clk2x_i[c]) disable iff (!rst_ni)
      (!ddr_i && wr_o[c]) |=> !wr_o[c]);
  end
endmodule

bind lane_write_frontend lwf_checker #(.NCH(NCH), .LANE_W(LANE_W)) u_chk (
  .clk2x_i    (clk2x_i),
  .rst_ni     (rst_ni),
  .phase_i    (phase_i),
  .dual_mode_i(dual_mode_i),
  .ddr_i      (ddr_i),
  .wen_ni     (wen_ni),
  .wcs_ni     (wcs_ni),
  .full_i     (full_i),
  .wr_o       (wr_o),
  .wdata_o    (wdata_o)
);

// File: tb/lane_write_frontend_tb.sv
module lane_write_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int LW  = 10;
  localparam int CW  = 20;

  logic             clk = 1'b0;
  logic [NCH-1:0]   run = '1;
  logic [NCH-1:0]   clk2x;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   phase = '0;
  logic             dual = 1'b0, wide = 1'b0, ddr = 1'b0;
  logic [NCH*LW-1:0] data = '0;
  logic [NCH-1:0]   wen_n = '1, wcs_n = '1, full = '0;
  logic [NCH-1:0]   wr;
  logic [NCH*CW-1:0] wdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign clk2x = {NCH{clk}} & run;

  lane_write_frontend u_dut (
    .clk2x_i(clk2x), .rst_ni(rst_n), .phase_i(phase), .dual_mode_i(dual),
    .lane_wide_i(wide), .ddr_i(ddr), .data_i(data), .wen_ni(wen_n),
    .wcs_ni(wcs_n), .full_i(full), .wr_o(wr), .wdata_o(wdata)
  );

  task automatic chk(input int c, input bit ew, input logic [CW-1:0] ed, input string r);
    checks++;
    if (wr[c] !== ew || wdata[c*CW +: CW] !== ed) begin
      fails++;
      $display("FAIL %s ch%0d: wr=%b data=%h expected wr=%b data=%h",
               r, c, wr[c], wdata[c*CW +: CW], ew, ed);
    end
  endtask

  function automatic logic [CW-1:0] narrow(input logic [NCH*LW-1:0] d, input int lo);
    return {{LW{1'b0}}, d[lo +: LW]};
  endfunction

  // starts and ends at a negedge
  task automatic do_reset(input bit m_dual, input bit m_wide, input bit m_ddr);
    rst_n = 1'b0;
    dual = m_dual; wide = m_wide; ddr = m_ddr;
    wen_n = '1; wcs_n = '1; full = '0; phase = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic slot(input bit ph, input logic [3:0] we, input logic [3:0] cs,
                      input logic [3:0] fu, input logic [39:0] d);
    phase = {NCH{ph}}; wen_n = we; wcs_n = cs; full = fu; data = d;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0);
    for (int c = 0; c < NCH; c++) chk(c, 0, '0, "R8 reset");
  endtask

  task automatic t_quad_sdr();
    logic [39:0] d = 40'hA5_3C96_1E0F;
    do_reset(0, 0, 0);
    slot(1, 4'h0, 4'h0, 4'h0, d);
    for (int c = 0; c < NCH; c++) chk(c, 1, narrow(d, c*LW), "R1 quad lanes");
    slot(0, 4'h0, 4'h0, 4'h0, ~d);
    for (int c = 0; c < NCH; c++) chk(c, 0, narrow(d, c*LW), "R5 sdr falling / R10 hold");
    slot(1, 4'b1001, 4'b1010, 4'h0, ~d);
    chk(0, 0, narrow(d, 0),  "R5 wen high");
    chk(1, 0, narrow(d, 10), "R5 wcs high");
    chk(2, 1, narrow(~d, 20), "R5 both low");
    chk(3, 0, narrow(d, 30), "R5 both high");
    slot(0, 4'hF, 4'hF, 4'h0, d);
    slot(1, 4'h0, 4'h0, 4'b0001, d);
    chk(0, 0, narrow(d, 0), "R7 full rising");
    chk(1, 1, narrow(d, 10), "R7 not full");
  endtask

  task automatic t_ddr();
    logic [39:0] a = 40'h12_3456_789A;
    logic [39:0] b = 40'hFE_DCBA_9876;
    do_reset(0, 0, 1);
    slot(1, 4'h0, 4'h0, 4'h0, a);
    for (int c = 0; c < NCH; c++) chk(c, 1, narrow(a, c*LW), "R6 ddr rising");
    slot(0, 4'hF, 4'hF, 4'h0, b);
    for (int c = 0; c < NCH; c++) chk(c, 1, narrow(b, c*LW), "R6 ddr falling ignores enables");
    slot(1, 4'hF, 4'h0, 4'h0, a);
    slot(0, 4'h0, 4'h0, 4'h0, a);
    for (int c = 0; c < NCH; c++) chk(c, 0, narrow(b, c*LW), "R6 falling does not sample");
    slot(1, 4'h0, 4'h0, 4'h0, a);
    slot(0, 4'h0, 4'h0, 4'b0010, b);
    chk(1, 0, narrow(a, 10), "R7 full falling");
    chk(0, 1, narrow(b, 0),  "R7 falling write");
  endtask

  task automatic t_dual(input bit w);
    logic [39:0] d = 40'h9C_5A3F_E217;
    do_reset(1, w, 0);
    slot(1, 4'h0, 4'h0, 4'h0, d);
    if (w) begin
      chk(0, 1, d[19:0],  "R2 dual x20 ch0");
      chk(2, 1, d[39:20], "R2 dual x20 ch2");
    end else begin
      chk(0, 1, narrow(d, 0),  "R3 dual x10 ch0");
      chk(2, 1, narrow(d, 20), "R3 dual x10 ch2");
    end
    chk(1, 0, '0, "R4 ch1 unused");
    chk(3, 0, '0, "R4 ch3 unused");
  endtask

  task automatic t_indep();
    logic [39:0] d = 40'h0F_F00F_F00F;
    do_reset(0, 0, 0);
    run[3] = 1'b0;
    slot(1, 4'h0, 4'h0, 4'h0, d);
    chk(0, 1, narrow(d, 0), "R9 running channel");
    chk(3, 0, '0, "R9 stopped channel");
    slot(0, 4'hF, 4'hF, 4'h0, d);
    run[3] = 1'b1;
    slot(1, 4'h0, 4'h0, 4'h0, d);
    chk(3, 1, narrow(d, 30), "R9 resumed channel");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_quad_sdr();
    t_ddr();
    t_dual(1);
    t_dual(0);
    t_indep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule